// File: doc/BRIEF.md
# Motor Pre-Driver Fault Response Controller

This block sits between the digitized fault flags of a motor pre-driver and the enables of its power sections. Six fault classes are handled: supply undervoltage, charge-pump undervoltage, overcurrent, gate-drive fault, controller watchdog expiry and over-temperature. Each class has its own set of outputs it may switch off and its own recovery rule.

A class recovers in one of three ways. Some classes follow their flag and release as soon as it drops. Some hold the bridge off for a fixed number of cycles and then check the flag again. The watchdog class stays latched until the host asks for a clear. Every output enable is the AND of the permissions granted by all classes. Sticky status bits record every class that has been seen, and an active-low summary output shows when the half-bridge is being held off.

Top module: `fault_response_ctrl`

## Requirements
- R1: A high `supply_uv` drives `bridge_en`, `pump_en` and `areg_en` low one cycle later. They return high one cycle after the flag drops, provided no other class still holds them.
- R2: A high `pump_uv` drives only `bridge_en` low one cycle later. `pump_en` and `areg_en` stay high, and the bridge follows the flag back.
- R3: Overcurrent is raised by `fet_ovl` or by `shunt_ovl`. From the cycle after detection it holds `bridge_en` low for exactly `RETRY_CYCLES` cycles, then releases it if both inputs are low.
- R4: A high `gate_flt` uses the same retry hold as R3. If the flag is still high in the last cycle of the hold, a fresh hold of `RETRY_CYCLES` cycles starts and the bridge stays off.
- R5: A high `wd_expire` holds `bridge_en` low from the next cycle on. The hold ends only on a cycle where `clear_req` is high and `wd_expire` is low.
- R6: A high `temp_hi` drives `bridge_en`, `pump_en` and `areg_en` low one cycle later. They return high one cycle after the flag drops.
- R7: `dreg_en` is high under every fault combination.
- R8: Each enable is the AND of all class permissions. An output released by one class stays low while any other class that covers it is still active.
- R9: `status` holds one sticky bit per class: bit 0 supply, bit 1 pump, bit 2 overcurrent, bit 3 gate, bit 4 watchdog, bit 5 temperature. A bit sets the cycle after its flag is seen. It clears on `clear_req` only if its flag is low in that cycle.
- R10: `fault_n` is low exactly while any class holds the half-bridge off.
- R11: During and right after reset, all enables are high, `fault_n` is high and `status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_uv | input | 1 | Supply undervoltage flag |
| pump_uv | input | 1 | Charge-pump undervoltage flag |
| fet_ovl | input | 1 | FET drain-source overload flag |
| shunt_ovl | input | 1 | Shunt-sense overload flag |
| gate_flt | input | 1 | Gate did not switch within the drive time |
| wd_expire | input | 1 | Controller watchdog expired |
| temp_hi | input | 1 | Over-temperature flag |
| clear_req | input | 1 | Host clear-fault write strobe |
| bridge_en | output | 1 | Half-bridge enable |
| pump_en | output | 1 | Charge-pump enable |
| areg_en | output | 1 | Analog regulator enable |
| dreg_en | output | 1 | Digital regulator enable |
| fault_n | output | 1 | Low while the half-bridge is held off |
| status | output | 6 | Sticky per-class fault bits |

## Verification
Two events can land in the same cycle: a host clear and a still-present fault flag, and a retry hold reaching its last cycle while the flag is still high. The bench provokes the first by pulsing `clear_req` while `wd_expire` or another flag is high, and checks that the hold and status bit survive. It provokes the second by keeping `gate_flt` high across a full hold and checking that the bridge stays off. A random phase mixes flags and clears. Every cycle is compared against a cycle model that is written from the requirements.

// File: rtl/fresp_pkg.sv
package fresp_pkg;

    localparam int NCLS = 6;

    typedef enum logic [2:0] {
        CLS_SUPPLY  = 3'd0,
        CLS_PUMP    = 3'd1,
        CLS_OVERCUR = 3'd2,
        CLS_GATE    = 3'd3,
        CLS_WDOG    = 3'd4,
        CLS_TEMP    = 3'd5
    } fault_cls_e;

    typedef enum logic [1:0] {
        REC_LEVEL,
        REC_RETRY,
        REC_HOST
    } recov_e;

    typedef struct packed {
        logic dreg;
        logic areg;
        logic pump;
        logic bridge;
    } enables_t;

    // Recovery rule chosen for each fault class
    function automatic recov_e recovery_of(input int cls);
        case (cls)
            int'(CLS_OVERCUR), int'(CLS_GATE): return REC_RETRY;
            int'(CLS_WDOG):                    return REC_HOST;
            default:                           return REC_LEVEL;
        endcase
    endfunction

    // Outputs a class switches off while it holds
    function automatic enables_t kills_of(input int cls);
        enables_t k;
        k = '0;
        k.bridge = 1'b1;
        if (cls == int'(CLS_SUPPLY) || cls == int'(CLS_TEMP)) begin
            k.pump = 1'b1;
            k.areg = 1'b1;
        end
        return k;
    endfunction

endpackage

// File: rtl/fresp_retry.sv
module fresp_retry #(
    parameter int RETRY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    output logic hold
);
    localparam int CW = (RETRY_CYCLES > 2) ? $clog2(RETRY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RETRY_CYCLES - 1);

    logic          hold_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!hold_q) begin
            if (flag) begin
                hold_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (cnt_q == LAST) begin
            if (flag) cnt_q  <= '0;
            else      hold_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hold = hold_q;

    // R3/R4: a hold never ends early and never ends while the flag is high
    p_no_early_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_q) |-> ($past(cnt_q) == LAST && !$past(flag)));
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (hold_q && cnt_q == LAST && flag) |=> (hold_q && cnt_q == '0));

endmodule

// File: rtl/fresp_hostclr.sv
module fresp_hostclr (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    input  logic clear_req,
    output logic hold
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst)                     hold_q <= 1'b0;
        else if (clear_req && !flag) hold_q <= 1'b0;
        else if (flag)               hold_q <= 1'b1;
    end

    assign hold = hold_q;

    // R5: only a host clear releases the latched hold
    p_latched_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !clear_req) |=> hold_q);
    p_clear_needs_low_r5: assert property (@(posedge clk) disable iff (rst)
        flag |=> hold_q);

endmodule

// File: rtl/fresp_status.sv
module fresp_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic         clear_req,
    output logic [N-1:0] stat
);
    logic [N-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= cond | (stat_q & ~{N{clear_req}});
    end

    assign stat = stat_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (stat_q[i] && !clear_req) |=> stat_q[i]);
        p_sets_r9: assert property (@(posedge clk) disable iff (rst)
            cond[i] |=> stat_q[i]);
    end

endmodule

// File: rtl/fault_response_ctrl.sv
module fault_response_ctrl
    import fresp_pkg::*;
#(
    parameter int RETRY_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            supply_uv,
    input  logic            pump_uv,
    input  logic            fet_ovl,
    input  logic            shunt_ovl,
    input  logic            gate_flt,
    input  logic            wd_expire,
    input  logic            temp_hi,
    input  logic            clear_req,
    output logic            bridge_en,
    output logic            pump_en,
    output logic            areg_en,
    output logic            dreg_en,
    output logic            fault_n,
    output logic [NCLS-1:0] status
);
    logic [NCLS-1:0] cond;
    logic [NCLS-1:0] hold;
    enables_t        en;

    assign cond[CLS_SUPPLY]  = supply_uv;
    assign cond[CLS_PUMP]    = pump_uv;
    assign cond[CLS_OVERCUR] = fet_ovl | shunt_ovl;
    assign cond[CLS_GATE]    = gate_flt;
    assign cond[CLS_WDOG]    = wd_expire;
    assign cond[CLS_TEMP]    = temp_hi;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        if (recovery_of(c) == REC_LEVEL) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) hold[c] <= 1'b0;
                else     hold[c] <= cond[c];
            end
        end else if (recovery_of(c) == REC_RETRY) begin : g_retry
            fresp_retry #(.RETRY_CYCLES(RETRY_CYCLES)) u_retry (
                .clk  (clk),
                .rst  (rst),
                .flag (cond[c]),
                .hold (hold[c])
            );
        end else begin : g_host
            fresp_hostclr u_host (
                .clk       (clk),
                .rst       (rst),
                .flag      (cond[c]),
                .clear_req (clear_req),
                .hold      (hold[c])
            );
        end
    end

    // Each enable is the AND of the permissions of all classes
    always_comb begin
        en = '1;
        for (int c = 0; c < NCLS; c++) begin
            if (hold[c]) en = en & ~kills_of(c);
        end
    end

    fresp_status #(.N(NCLS)) u_status (
        .clk       (clk),
        .rst       (rst),
        .cond      (cond),
        .clear_req (clear_req),
        .stat      (status)
    );

    assign bridge_en = en.bridge;
    assign pump_en   = en.pump;
    assign areg_en   = en.areg;
    assign dreg_en   = en.dreg;
    assign fault_n   = ~|hold;

    p_supply_cut_r1: assert property (@(posedge clk) disable iff (rst)
        supply_uv |=> (!bridge_en && !pump_en && !areg_en));
    p_pump_only_r2: assert property (@(posedge clk) disable iff (rst)
        (pump_uv && !supply_uv && !temp_hi) |=> (!bridge_en && pump_en && areg_en));
    p_temp_cut_r6: assert property (@(posedge clk) disable iff (rst)
        temp_hi |=> (!bridge_en && !pump_en && !areg_en));
    p_any_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (|cond) |=> !fault_n);

endmodule

// File: tb/sim_fault_response_ctrl.sv
module sim_fault_response_ctrl;
    localparam int RC = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_uv = 0, pump_uv = 0, fet_ovl = 0, shunt_ovl = 0;
    logic gate_flt = 0, wd_expire = 0, temp_hi = 0, clear_req = 0;
    logic bridge_en, pump_en, areg_en, dreg_en, fault_n;
    logic [5:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fault_response_ctrl #(.RETRY_CYCLES(RC)) u0 (
        .clk(clk), .rst(rst), .supply_uv(supply_uv), .pump_uv(pump_uv),
        .fet_ovl(fet_ovl), .shunt_ovl(shunt_ovl), .gate_flt(gate_flt),
        .wd_expire(wd_expire), .temp_hi(temp_hi), .clear_req(clear_req),
        .bridge_en(bridge_en), .pump_en(pump_en), .areg_en(areg_en),
        .dreg_en(dreg_en), .fault_n(fault_n), .status(status)
    );

    // Cycle model built from the requirements
    logic [5:0] m_hold = '0;
    logic [5:0] m_stat = '0;
    int         m_cnt [2:3];

    function automatic logic [5:0] conds();
        return {temp_hi, wd_expire, gate_flt, fet_ovl | shunt_ovl, pump_uv, supply_uv};
    endfunction

    always @(posedge clk) begin
        logic [5:0] c;
        c = conds();
        if (rst) begin
            m_hold = '0; m_stat = '0; m_cnt[2] = 0; m_cnt[3] = 0;
        end else begin
            m_hold[0] = c[0];
            m_hold[1] = c[1];
            m_hold[5] = c[5];
            for (int k = 2; k <= 3; k++) begin
                if (!m_hold[k]) begin
                    if (c[k]) begin m_hold[k] = 1'b1; m_cnt[k] = 0; end
                end else if (m_cnt[k] == RC - 1) begin
                    if (c[k]) m_cnt[k] = 0; else m_hold[k] = 1'b0;
                end else m_cnt[k] = m_cnt[k] + 1;
            end
            if (clear_req && !c[4]) m_hold[4] = 1'b0;
            else if (c[4])          m_hold[4] = 1'b1;
            m_stat = c | (m_stat & ~{6{clear_req}});
        end
    end

    function automatic logic exp_bridge(logic [5:0] h); return h == 6'd0; endfunction
    function automatic logic exp_pump(logic [5:0] h);   return !(h[0] | h[5]); endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cmp_model(string tag);
        check({tag, " bridge_en (R8)"}, 8'(bridge_en), 8'(exp_bridge(m_hold)));
        check({tag, " pump_en (R8)"},   8'(pump_en),   8'(exp_pump(m_hold)));
        check({tag, " areg_en (R8)"},   8'(areg_en),   8'(exp_pump(m_hold)));
        check({tag, " dreg_en (R7)"},   8'(dreg_en),   8'd1);
        check({tag, " fault_n (R10)"},  8'(fault_n),   8'(exp_bridge(m_hold)));
        check({tag, " status (R9)"},    8'(status),    8'(m_stat));
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        // R11: reset state
        check("R11 enables", {4'd0, dreg_en, areg_en, pump_en, bridge_en}, 8'h0f);
        check("R11 fault_n", 8'(fault_n), 8'd1);
        check("R11 status", 8'(status), 8'd0);
        rst = 1'b0;
        step(1);
        cmp_model("R11 after reset");

        // R1 supply undervoltage
        supply_uv = 1; step(1);
        check("R1 off", {4'd0, dreg_en, areg_en, pump_en, bridge_en}, 8'h08);
        supply_uv = 0; step(1);
        check("R1 back", {4'd0, dreg_en, areg_en, pump_en, bridge_en}, 8'h0f);
        check("R9 supply bit", 8'(status), 8'h01);
        clear_req = 1; step(1); clear_req = 0;
        check("R9 cleared", 8'(status), 8'h00);

        // R2 pump undervoltage
        pump_uv = 1; step(1);
        check("R2 bridge only", {4'd0, dreg_en, areg_en, pump_en, bridge_en}, 8'h0e);
        pump_uv = 0; step(1);
        check("R2 back", 8'(bridge_en), 8'd1);

        // R3 overcurrent via shunt, exact hold length
        shunt_ovl = 1; step(1); shunt_ovl = 0;
        check("R3 off", 8'(bridge_en), 8'd0);
        step(RC - 1);
        check("R3 still off at end", 8'(bridge_en), 8'd0);
        step(1);
        check("R3 released", 8'(bridge_en), 8'd1);
        check("R9 overcurrent bit", 8'(status[2]), 8'd1);
        fet_ovl = 1; step(1); fet_ovl = 0;
        check("R3 fet path", 8'(bridge_en), 8'd0);
        step(RC);
        check("R3 fet released", 8'(bridge_en), 8'd1);

        // R4 gate fault held across the end of a hold: restart
        gate_flt = 1; step(RC);
        check("R4 off", 8'(bridge_en), 8'd0);
        step(2); gate_flt = 0;
        check("R4 restarted", 8'(bridge_en), 8'd0);
        step(RC - 2);
        check("R4 second hold", 8'(bridge_en), 8'd0);
        step(1);
        check("R4 released", 8'(bridge_en), 8'd1);

        // R5 watchdog: clear while flag high is ignored
        wd_expire = 1; step(1);
        check("R5 off", 8'(bridge_en), 8'd0);
        clear_req = 1; step(1); clear_req = 0;
        check("R5 clear ignored", 8'(bridge_en), 8'd0);
        check("R9 wd bit kept", 8'(status[4]), 8'd1);
        wd_expire = 0; step(5);
        check("R5 latched", 8'(fault_n), 8'd0);
        clear_req = 1; step(1); clear_req = 0;
        check("R5 cleared", 8'(bridge_en), 8'd1);

        // R6 over-temperature overlapping pump undervoltage (R8)
        temp_hi = 1; pump_uv = 1; step(1);
        check("R6 off", {4'd0, dreg_en, areg_en, pump_en, bridge_en}, 8'h08);
        temp_hi = 0; step(1);
        check("R8 pump back bridge held", {4'd0, dreg_en, areg_en, pump_en, bridge_en}, 8'h0e);
        pump_uv = 0; step(1);
        check("R6 all back", {4'd0, dreg_en, areg_en, pump_en, bridge_en}, 8'h0f);
        clear_req = 1; step(1); clear_req = 0;
        cmp_model("R9 directed end");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            cmp_model("random");
            if ($urandom_range(15) == 0) supply_uv = ~supply_uv;
            if ($urandom_range(15) == 0) pump_uv   = ~pump_uv;
            if ($urandom_range(31) == 0) fet_ovl   = ~fet_ovl;
            if ($urandom_range(31) == 0) shunt_ovl = ~shunt_ovl;
            if ($urandom_range(31) == 0) gate_flt  = ~gate_flt;
            if ($urandom_range(31) == 0) wd_expire = ~wd_expire;
            if ($urandom_range(15) == 0) temp_hi   = ~temp_hi;
            clear_req = ($urandom_range(19) == 0);
            step(1);
        end
        cmp_model("random end");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule